// File: doc/BRIEF.md
# APB Burst Requester

This block is a bus requester that turns commands from a local command port into APB transfers. A command names its kind (idle, write or read), a start address, a burst length code and a number of idle cycles to insert after each transfer. The block then drives select, enable, address, direction and write data. Each word takes a setup cycle followed by an access cycle, and the words of a burst go to rising word addresses.

Write data is pulled one word at a time. The block raises a pop strobe in the cycle in which it captures the word on `wr_data`. The source then presents the next word. Every access cycle, for reads and for writes, is reported on a response port one cycle later, and for reads that report carries the sampled read data. Between transfers the address and direction lines hold their last values and only select, enable and write data go quiet. This keeps switching low.

Top module: `apb_burst_requester`

## Requirements
- R1: While `rst_n` is low, `bus_sel`, `bus_en`, `bus_addr`, `bus_wr`, `bus_wdata` and `rsp_valid` are 0. Once reset is released with no command pending, `cmd_ready` is 1.
- R2: A transfer takes exactly two cycles. The setup cycle has `bus_sel`=1 and `bus_en`=0, with address, direction and write data valid. The access cycle that follows has `bus_sel`=1 and `bus_en`=1, and the other lines are unchanged. For a read, `bus_wdata` is 0.
- R3: After each transfer the block inserts `cmd_gap` idle cycles, as latched with the command. In every idle cycle `bus_sel`=0, `bus_en`=0 and `bus_wdata`=0, while `bus_addr` and `bus_wr` keep their previous values.
- R4: With `cmd_gap`=0, the setup cycle of the next word of a burst follows the access cycle directly, so consecutive access cycles are 2 cycles apart. A single-word command with gap 0 that is followed by a waiting command has its successor's setup directly after its access cycle.
- R5: `cmd_len` selects the word count: code 0 gives 1 word, 1 gives 4, 2 gives 8, 3 gives 16 and 4 gives 32. Codes 5 to 7 give 1 word. Word i of a burst uses address start+4*i.
- R6: After the last word of a multi-word burst with gap 0, exactly one idle cycle separates its access cycle from the setup cycle of a waiting command.
- R7: `rsp_valid` pulses for one cycle in the cycle after every access cycle. `rsp_write` gives that transfer's direction. For a read, `rsp_data` equals `bus_rdata` as sampled during the access cycle. For a write, `rsp_data` is 0.
- R8: Command kind encoding: 0 is idle, 1 is write, 2 is read, and 3 is treated as idle. An idle command takes one cycle with `bus_sel`=0, `bus_en`=0 and `bus_wdata`=0. A waiting transfer command can be accepted at the end of that cycle.
- R9: Bits 1:0 of `bus_addr` are always driven 0, whatever the low bits of `cmd_addr` are.
- R10: An assertion of `rst_n` low in the middle of a transfer forces `bus_sel`, `bus_en`, `bus_addr`, `bus_wr` and `bus_wdata` to 0 at once, without waiting for a clock edge.
- R11: `wd_pop` is 1 exactly in the cycle whose closing edge captures `wr_data` into a write setup cycle. Word i of a write burst therefore carries the i-th word presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted at this edge if valid |
| cmd_kind | input | 2 | 0 idle, 1 write, 2 read, 3 idle |
| cmd_addr | input | AW | Start byte address |
| cmd_len | input | 3 | Burst length code |
| cmd_gap | input | GW | Idle cycles after each transfer |
| wr_data | input | DW | Current write word |
| wd_pop | output | 1 | Current write word is taken at this edge |
| bus_sel | output | 1 | Bus select |
| bus_en | output | 1 | Bus enable (access phase) |
| bus_addr | output | AW | Bus address |
| bus_wr | output | 1 | Bus direction, 1 = write |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_data | output | DW | Read data of the response |

## Verification
The bench drives single writes and single reads, a 4-word write burst with zero gap followed by a waiting read, and write and read bursts with non-zero gaps. It also runs the 16-word and 32-word read bursts, an idle command placed between two writes, and a misaligned start address. Measuring the distance between access cycles tells a zero gap from a programmed gap, and tells the release cycle after a burst from a direct hand-over. Checking address, direction and write data in the idle cycles separates held lines from cleared ones. Tying read data to the address shows that each response comes from the right access cycle. A reset dropped in the middle of a burst and checked before the next edge shows that the clear is asynchronous.

// File: rtl/apbq_pkg.sv
package apbq_pkg;

    localparam int MAX_WORDS = 32;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2,
        K_SPARE = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        PH_REST   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACCESS = 3'd2,
        PH_GAP    = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    // Word count for a length code; unknown codes fall back to a single word.
    function automatic logic [CNT_W-1:0] burst_words(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        n = CNT_W'(1);
        if (code >= 3'd1 && code <= 3'd4)
            n = CNT_W'(1) << (code + 3'd1);
        return n;
    endfunction

endpackage

// File: rtl/apbq_ctrl.sv
module apbq_ctrl
    import apbq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_kind,
    input  logic [AW-1:0] cmd_addr,
    input  logic [2:0]    cmd_len,
    input  logic [GW-1:0] cmd_gap,
    input  logic [DW-1:0] wr_data,
    output logic          wd_pop,
    output logic          bus_sel,
    output logic          bus_en,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata
);

    localparam logic [AW-1:0] STEP  = AW'(4);
    localparam logic [AW-1:0] AMASK = ~AW'(3);

    typedef struct packed {
        phase_e           ph;
        logic [AW-1:0]    addr;
        logic             wr;
        logic             sel;
        logic             en;
        logic [DW-1:0]    wdata;
        logic [CNT_W-1:0] left;
        logic [GW:0]      gcnt;
        logic [GW-1:0]    gap;
        logic             burst;
    } st_t;

    st_t s_d, s_q;

    logic [GW:0]      gap_eff;
    logic             go_next;
    logic             go_rest;
    logic             take;
    logic [CNT_W-1:0] words;

    always_comb begin
        s_d     = s_q;
        go_next = 1'b0;
        go_rest = 1'b0;
        cmd_ready = 1'b0;
        wd_pop  = 1'b0;
        words   = burst_words(cmd_len);

        // the final word of a burst always gets at least one releasing idle cycle
        if (s_q.left == '0 && s_q.burst && s_q.gap == '0)
            gap_eff = (GW+1)'(1);
        else
            gap_eff = {1'b0, s_q.gap};

        case (s_q.ph)
            PH_REST: cmd_ready = 1'b1;
            PH_HOLD: begin
                cmd_ready = 1'b1;
                s_d.ph    = PH_REST;
            end
            PH_SETUP: begin
                s_d.ph = PH_ACCESS;
                s_d.en = 1'b1;
            end
            PH_ACCESS: begin
                if (gap_eff != '0) begin
                    s_d.ph    = PH_GAP;
                    s_d.gcnt  = gap_eff;
                    s_d.sel   = 1'b0;
                    s_d.en    = 1'b0;
                    s_d.wdata = '0;
                end else if (s_q.left != '0) begin
                    go_next = 1'b1;
                end else begin
                    go_rest   = 1'b1;
                    cmd_ready = 1'b1;
                end
            end
            PH_GAP: begin
                if (s_q.gcnt <= (GW+1)'(1)) begin
                    if (s_q.left != '0) begin
                        go_next = 1'b1;
                    end else begin
                        go_rest   = 1'b1;
                        cmd_ready = 1'b1;
                    end
                end else begin
                    s_d.gcnt = s_q.gcnt - (GW+1)'(1);
                end
            end
            default: s_d.ph = PH_REST;
        endcase

        if (go_rest) begin
            s_d.ph    = PH_REST;
            s_d.sel   = 1'b0;
            s_d.en    = 1'b0;
            s_d.wdata = '0;
        end

        if (go_next) begin
            s_d.ph    = PH_SETUP;
            s_d.sel   = 1'b1;
            s_d.en    = 1'b0;
            s_d.addr  = s_q.addr + STEP;
            s_d.left  = s_q.left - CNT_W'(1);
            s_d.wdata = s_q.wr ? wr_data : '0;
            wd_pop    = s_q.wr;
        end

        take = cmd_ready && cmd_valid;
        if (take) begin
            if (cmd_kind == K_WRITE || cmd_kind == K_READ) begin
                s_d.ph    = PH_SETUP;
                s_d.sel   = 1'b1;
                s_d.en    = 1'b0;
                s_d.addr  = cmd_addr & AMASK;
                s_d.wr    = (cmd_kind == K_WRITE);
                s_d.wdata = (cmd_kind == K_WRITE) ? wr_data : '0;
                wd_pop    = (cmd_kind == K_WRITE);
                s_d.left  = words - CNT_W'(1);
                s_d.gap   = cmd_gap;
                s_d.burst = (words != CNT_W'(1));
            end else begin
                s_d.ph    = PH_HOLD;
                s_d.sel   = 1'b0;
                s_d.en    = 1'b0;
                s_d.wdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_sel   = s_q.sel;
    assign bus_en    = s_q.en;
    assign bus_addr  = s_q.addr;
    assign bus_wr    = s_q.wr;
    assign bus_wdata = s_q.wdata;

    a_r2_setup_then_access: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sel && !s_q.en) |=> (s_q.sel && s_q.en));

    a_r2_enable_has_select: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.en |-> s_q.sel);

    a_r3_idle_keeps_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.sel |-> ($stable(s_q.addr) && $stable(s_q.wr)));

    a_r8_quiet_wdata: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.sel |-> (s_q.wdata == '0));

    a_r11_pop_feeds_setup: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pop |=> (s_q.sel && !s_q.en && s_q.wr));

endmodule

// File: rtl/apbq_resp.sv
module apbq_resp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_done,
    input  logic          xfer_wr,
    input  logic [DW-1:0] rd_in,
    output logic          rsp_valid,
    output logic          rsp_write,
    output logic [DW-1:0] rsp_data
);

    typedef struct packed {
        logic          valid;
        logic          write;
        logic [DW-1:0] data;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d       = '0;
        r_d.valid = xfer_done;
        r_d.write = xfer_done && xfer_wr;
        if (xfer_done && !xfer_wr)
            r_d.data = rd_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.valid;
    assign rsp_write = r_q.write;
    assign rsp_data  = r_q.data;

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/apb_burst_requester.sv
module apb_burst_requester #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_kind,
    input  logic [AW-1:0] cmd_addr,
    input  logic [2:0]    cmd_len,
    input  logic [GW-1:0] cmd_gap,
    input  logic [DW-1:0] wr_data,
    output logic          wd_pop,
    output logic          bus_sel,
    output logic          bus_en,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          rsp_valid,
    output logic          rsp_write,
    output logic [DW-1:0] rsp_data
);

    logic xfer_done;

    apbq_ctrl #(.AW(AW), .DW(DW), .GW(GW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_gap   (cmd_gap),
        .wr_data   (wr_data),
        .wd_pop    (wd_pop),
        .bus_sel   (bus_sel),
        .bus_en    (bus_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata)
    );

    assign xfer_done = bus_sel && bus_en;

    apbq_resp #(.DW(DW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_done (xfer_done),
        .xfer_wr   (bus_wr),
        .rd_in     (bus_rdata),
        .rsp_valid (rsp_valid),
        .rsp_write (rsp_write),
        .rsp_data  (rsp_data)
    );

endmodule

// File: tb/apb_burst_requester_bench.sv
module apb_burst_requester_bench;
    import apbq_pkg::*;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int GW = 4;
    localparam int TN = 1024;
    localparam logic [31:0] RD_KEY = 32'hA5A5_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_kind = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [2:0]    cmd_len = 3'd0;
    logic [GW-1:0] cmd_gap = '0;
    logic [DW-1:0] wr_data;
    logic          wd_pop;
    logic          bus_sel, bus_en, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          rsp_valid, rsp_write;
    logic [DW-1:0] rsp_data;

    always #5 clk = ~clk;

    apb_burst_requester #(.AW(AW), .DW(DW), .GW(GW)) u_apb_burst_requester (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_gap(cmd_gap),
        .wr_data(wr_data), .wd_pop(wd_pop), .bus_sel(bus_sel), .bus_en(bus_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_data(rsp_data)
    );

    assign bus_rdata = bus_addr ^ RD_KEY;

    // write data source: advances one word per pop
    logic [31:0] wbase = 32'h0;
    logic [31:0] wptr  = 32'h0;
    logic        wclr  = 1'b0;
    assign wr_data = wbase + wptr;
    always @(posedge clk) begin
        if (wclr)        wptr <= 32'h0;
        else if (wd_pop) wptr <= wptr + 32'h1;
    end

    // per-cycle trace, sampled at the falling edge
    logic        tr_clr = 1'b0;
    int          tr_n = 0;
    int          rn = 0;
    logic        t_sel [TN];
    logic        t_en  [TN];
    logic        t_wr  [TN];
    logic [31:0] t_addr[TN];
    logic [31:0] t_wd  [TN];
    logic [31:0] r_data[256];
    logic        r_wr  [256];
    int          r_idx [256];

    always @(negedge clk) begin
        if (tr_clr) begin
            tr_n <= 0;
            rn   <= 0;
        end else begin
            if (tr_n < TN) begin
                t_sel[tr_n]  <= bus_sel;
                t_en[tr_n]   <= bus_en;
                t_wr[tr_n]   <= bus_wr;
                t_addr[tr_n] <= bus_addr;
                t_wd[tr_n]   <= bus_wdata;
            end
            tr_n <= tr_n + 1;
            if (rsp_valid && rn < 256) begin
                r_data[rn] <= rsp_data;
                r_wr[rn]   <= rsp_write;
                r_idx[rn]  <= tr_n;
                rn <= rn + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int a_idx[64];
    int na = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic begin_trace();
        tr_clr = 1'b1;
        wclr   = 1'b1;
        tick();
        tr_clr = 1'b0;
        wclr   = 1'b0;
    endtask

    task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [2:0] l, input logic [3:0] g);
        bit r;
        cmd_kind  = k;
        cmd_addr  = a;
        cmd_len   = l;
        cmd_gap   = g;
        cmd_valid = 1'b1;
        do begin
            r = cmd_ready;
            tick();
        end while (!r);
    endtask

    task automatic settle();
        cmd_valid = 1'b0;
        do tick(); while (!(cmd_ready && !bus_sel));
        tick();
        tick();
    endtask

    task automatic scan();
        na = 0;
        for (int i = 0; i < tr_n && i < TN; i++) begin
            if (t_sel[i] && t_en[i] && na < 64) begin
                a_idx[na] = i;
                na++;
            end
        end
    endtask

    task automatic t_reset();
        check(bus_sel == 0 && bus_en == 0 && bus_wr == 0, "R1 control lines in reset", {29'd0, bus_sel, bus_en, bus_wr}, 0);
        check(bus_addr == 0 && bus_wdata == 0, "R1 addr/wdata in reset", bus_addr | bus_wdata, 0);
        check(rsp_valid == 0, "R1 rsp_valid in reset", rsp_valid, 0);
        tick();
        rst_n = 1'b1;
        tick();
        check(cmd_ready == 1, "R1 ready after reset", cmd_ready, 1);
    endtask

    task automatic t_single_write();
        int s;
        wbase = 32'h1234_0000;
        begin_trace();
        issue(K_WRITE, 32'h100, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 1, "R2 one access for single write", na, 1);
        s = a_idx[0] - 1;
        check(t_sel[s] && !t_en[s] && t_wr[s], "R2 setup phase lines", {t_sel[s], t_en[s], t_wr[s]}, 3'b101);
        check(t_addr[s] == 32'h100 && t_wd[s] == 32'h1234_0000, "R2 setup addr/data", t_wd[s], 32'h1234_0000);
        check(t_addr[a_idx[0]] == 32'h100 && t_wd[a_idx[0]] == 32'h1234_0000, "R2 access holds lines", t_addr[a_idx[0]], 32'h100);
        check(rn == 1 && r_wr[0] == 1 && r_data[0] == 0, "R7 write response", r_data[0], 0);
        check(r_idx[0] == a_idx[0] + 1, "R7 response one cycle after access", r_idx[0], a_idx[0] + 1);
        check(!t_sel[tr_n-1] && t_addr[tr_n-1] == 32'h100 && t_wr[tr_n-1] && t_wd[tr_n-1] == 0,
              "R3 idle holds addr and direction", t_addr[tr_n-1], 32'h100);
    endtask

    task automatic t_single_read();
        begin_trace();
        issue(K_READ, 32'h204, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 1 && !t_wr[a_idx[0]], "R2 single read access", na, 1);
        check(t_wd[a_idx[0] - 1] == 0, "R2 read setup wdata zero", t_wd[a_idx[0] - 1], 0);
        check(rn == 1 && !r_wr[0] && r_data[0] == (32'h204 ^ RD_KEY), "R7 read data returned", r_data[0], 32'h204 ^ RD_KEY);
    endtask

    task automatic t_align();
        begin_trace();
        issue(K_WRITE, 32'h10B, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 1 && t_addr[a_idx[0]] == 32'h108, "R9 low address bits cleared", t_addr[a_idx[0]], 32'h108);
    endtask

    task automatic t_burst_back();
        int bad_a, bad_d, bad_g, bad_s;
        bad_a = 0; bad_d = 0; bad_g = 0; bad_s = 0;
        wbase = 32'hC0DE_0000;
        begin_trace();
        issue(K_WRITE, 32'h40, 3'd1, 4'd0);
        issue(K_READ, 32'h80, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 5, "R5 four-word burst plus one read", na, 5);
        for (int i = 0; i < 4; i++) begin
            if (t_addr[a_idx[i]] != 32'h40 + 4 * i) bad_a++;
            if (t_wd[a_idx[i]] != wbase + i) bad_d++;
            if (!(t_sel[a_idx[i] - 1] && !t_en[a_idx[i] - 1])) bad_s++;
            if (i < 3 && a_idx[i+1] - a_idx[i] != 2) bad_g++;
        end
        check(bad_a == 0, "R5 burst addresses step by 4", bad_a, 0);
        check(bad_d == 0, "R11 burst data in pop order", bad_d, 0);
        check(bad_s == 0, "R2 setup before each access", bad_s, 0);
        check(bad_g == 0, "R4 zero gap back-to-back words", bad_g, 0);
        check(a_idx[4] - a_idx[3] == 3 && !t_sel[a_idx[3] + 1], "R6 one release cycle after burst", a_idx[4] - a_idx[3], 3);
        check(t_addr[a_idx[4]] == 32'h80 && !t_wr[a_idx[4]], "R4 waiting read follows", t_addr[a_idx[4]], 32'h80);
    endtask

    task automatic t_single_chain();
        begin_trace();
        issue(K_WRITE, 32'h600, 3'd0, 4'd0);
        issue(K_READ, 32'h604, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 2 && a_idx[1] - a_idx[0] == 2, "R4 single then waiting command without gap", a_idx[1] - a_idx[0], 2);
    endtask

    task automatic t_gap();
        int bad_g, bad_i, bad_r;
        bad_g = 0; bad_i = 0; bad_r = 0;
        wbase = 32'h5500_0000;
        begin_trace();
        issue(K_WRITE, 32'h300, 3'd1, 4'd2);
        settle();
        scan();
        check(na == 4, "R5 four words with gap", na, 4);
        for (int i = 0; i < 3; i++) begin
            if (a_idx[i+1] - a_idx[i] != 4) bad_g++;
            for (int j = 1; j <= 2; j++) begin
                int c;
                c = a_idx[i] + j;
                if (t_sel[c] || t_en[c] || t_wd[c] != 0 || !t_wr[c] || t_addr[c] != 32'h300 + 4 * i) bad_i++;
            end
        end
        check(bad_g == 0, "R3 two idle cycles between words", bad_g, 0);
        check(bad_i == 0, "R3 idle cycles quiet with held lines", bad_i, 0);
        begin_trace();
        issue(K_READ, 32'h800, 3'd2, 4'd1);
        settle();
        scan();
        check(na == 8, "R5 eight-word read burst", na, 8);
        bad_g = 0;
        for (int i = 0; i < 7; i++) if (a_idx[i+1] - a_idx[i] != 3) bad_g++;
        check(bad_g == 0, "R3 one idle cycle between read words", bad_g, 0);
        for (int i = 0; i < 8; i++) if (r_data[i] != ((32'h800 + 4 * i) ^ RD_KEY) || r_wr[i]) bad_r++;
        check(rn == 8 && bad_r == 0, "R7 eight read responses", bad_r, 0);
    endtask

    task automatic t_long();
        int bad;
        begin_trace();
        issue(K_READ, 32'h2000, 3'd4, 4'd0);
        settle();
        scan();
        bad = 0;
        for (int i = 0; i < 31; i++) if (a_idx[i+1] - a_idx[i] != 2) bad++;
        check(na == 32 && t_addr[a_idx[31]] == 32'h207C, "R5 32-word burst length and end address", na, 32);
        check(bad == 0, "R4 32-word burst back-to-back", bad, 0);
        begin_trace();
        issue(K_READ, 32'h3000, 3'd3, 4'd0);
        settle();
        scan();
        check(na == 16 && t_addr[a_idx[15]] == 32'h303C, "R5 16-word burst", na, 16);
        begin_trace();
        issue(K_READ, 32'h3100, 3'd6, 4'd0);
        settle();
        scan();
        check(na == 1, "R5 spare length code gives one word", na, 1);
    endtask

    task automatic t_idle_cmd();
        wbase = 32'h7700_0000;
        begin_trace();
        issue(K_WRITE, 32'h500, 3'd0, 4'd0);
        issue(K_IDLE, 32'hFFF0, 3'd0, 4'd0);
        issue(K_WRITE, 32'h504, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 2 && a_idx[1] - a_idx[0] == 3, "R8 idle command takes one cycle", a_idx[1] - a_idx[0], 3);
        check(!t_sel[a_idx[0] + 1] && t_wd[a_idx[0] + 1] == 0 && t_addr[a_idx[0] + 1] == 32'h500,
              "R8 idle command cycle is quiet", t_wd[a_idx[0] + 1], 0);
        begin_trace();
        issue(2'd3, 32'h0, 3'd0, 4'd0);
        settle();
        scan();
        check(na == 0, "R8 kind 3 issues no transfer", na, 0);
    endtask

    task automatic t_areset();
        wbase = 32'h9900_0000;
        begin_trace();
        issue(K_WRITE, 32'h900, 3'd2, 4'd0);
        cmd_valid = 1'b0;
        tick();
        tick();
        tick();
        #2;
        rst_n = 1'b0;
        #1;
        check(!bus_sel && !bus_en && !bus_wr, "R10 controls cleared at once", {29'd0, bus_sel, bus_en, bus_wr}, 0);
        check(bus_addr == 0 && bus_wdata == 0, "R10 addr/wdata cleared at once", bus_addr | bus_wdata, 0);
        tick();
        rst_n = 1'b1;
        tick();
        check(cmd_ready && !bus_sel, "R1 ready after mid-burst reset", cmd_ready, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single_write();
                t_single_read();
                t_align();
                t_burst_back();
                t_single_chain();
                t_gap();
                t_long();
                t_idle_cmd();
                t_areset();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule